// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block serves word reads from a simple memory bus by running one serial flash read transaction per bus request. A single packed 32-bit setup word describes the whole transaction: the read opcode, how many address bytes follow it, how many dummy cycles come next, and whether the data arrives on one lane or on four lanes. Each bus read clocks in four flash bytes and returns them as one little-endian 32-bit word. Chip select is released after every word.

The engine owns the pins only while the memory-switch input is set. A chip-select map input names the flash device as index + 1, and the value zero disables the mapping. A request that arrives while the switch is cleared, or while the map is zero or out of range, is answered at once with an error and causes no pin activity. The engine runs in SPI mode 0. SCLK idles low, and each SCLK period lasts two system clock cycles. The engine samples read data on the rising edge of SCLK, and the flash is expected to change its outputs after the falling edge.

Top module: `sfr_xip_rd`

## Requirements
- R1: After reset, every chip select is high, SCLK is low, the lane-0 output enable is low and bus_valid_o is low.
- R2: The read opcode in setup bits 7:0 is sent first on lane 0, MSB first. There is one bit per SCLK, and it is driven with the output enable high.
- R3: Setup bits 9:8 holding the value n send n+1 address bytes right after the opcode. These are the low-order n+1 bytes of the bus address, zero-extended to 32 bits and sent MSB first on lane 0.
- R4: After the address, the engine issues 8×(setup bits 11:10) + (setup bits 28:24) dummy SCLK cycles. During the dummy and data phases, lane 0 is not driven.
- R5: When setup bits 13:12 are not 3, data is read from lane 1 at one bit per SCLK over 32 SCLK cycles.
- R6: When setup bits 13:12 equal 3, data is read from lanes 3..0 at four bits per SCLK over 8 SCLK cycles. Lane 3 carries the most significant bit, and the high nibble of each byte comes first.
- R7: The first flash byte lands in bus_rdata_o bits 7:0 and the fourth in bits 31:24. Each byte is received MSB first.
- R8: During a read, exactly one chip select is low: cs_no[map−1]. All chip selects are high again in the cycle in which bus_valid_o is asserted.
- R9: A request made while mem_sw_i is low, cs_map_i is 0, or cs_map_i exceeds the number of chip selects is answered in the next cycle with bus_valid_o and bus_err_o high and bus_rdata_o zero. Such a request produces no SCLK edge and no chip-select activity.
- R10: Setup bits 23:16 (the write opcode) have no effect on a read.
- R11: SCLK is high for one clock cycle and low for one clock cycle. For a read with N SCLK cycles in total, bus_valid_o rises 2N clock edges after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 32 | Packed read setup word |
| mem_sw_i | input | 1 | Memory switch: 1 gives the pins to this engine |
| cs_map_i | input | CSW | Chip select for mapped reads as index+1; 0 disables |
| bus_req_i | input | 1 | One-cycle read strobe, accepted when idle |
| bus_addr_i | input | AW | Byte address of the read |
| bus_valid_o | output | 1 | One-cycle response strobe |
| bus_err_o | output | 1 | Error flag qualifying bus_valid_o |
| bus_rdata_o | output | 32 | Read data word |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | NCS | Chip selects, active low |
| mosi_o | output | 1 | Lane 0 output |
| mosi_oe_o | output | 1 | Lane 0 output enable |
| lane_i | input | 4 | Data lanes 3..0 input |

## Verification
The bench builds the engine with NCS=4 and AW=24. With these values the 3-bit map field can hold the out-of-range value 5, and the four-byte address setting must pad above a 24-bit bus address. The bench sweeps every address-byte count, every dummy-byte count and every lane mode, together with three dummy-bit counts. A behavioural flash in the bench serves data computed from the address, and the bench checks the word, the opcode and address bits shifted out, the SCLK count and the latency for each setting.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DUMMY, ST_DATA} st_e;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [4:0] dbits;
    logic [7:0] wr_op;
    logic [1:0] rsv_lo;
    logic [1:0] mode;
    logic [1:0] dbytes;
    logic [1:0] abytes;
    logic [7:0] rd_op;
  } setup_t;

  localparam logic [1:0] MODE_QUAD = 2'd3;
endpackage

// File: rtl/sfr_cs_dec.sv
module sfr_cs_dec #(
  parameter int NCS = 4,
  localparam int CSW = $clog2(NCS + 1)
) (
  input  logic [CSW-1:0] map_i,
  output logic [NCS-1:0] oh_o,
  output logic           ok_o
);
  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign oh_o[g] = (map_i == CSW'(g + 1));
  end
  assign ok_o = |oh_o;
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq import sfr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [6:0] cmd_bits_i,
  input  logic [6:0] dmy_bits_i,
  input  logic [6:0] dat_clks_i,
  output st_e        st_o,
  output logic       sclk_o,
  output logic       shift_o,
  output logic       smp_o,
  output logic       done_o
);
  st_e        st_q;
  logic       sclk_q;
  logic [6:0] cnt_q, dmy_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      dmy_q  <= '0;
      dat_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      sclk_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_CMD;
        cnt_q <= cmd_bits_i - 7'd1;
        dmy_q <= dmy_bits_i;
        dat_q <= dat_clks_i;
      end
    end else begin
      sclk_q <= ~sclk_q;
      // phase boundaries sit on falling edges
      if (sclk_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 7'd1;
        end else if (st_q == ST_CMD && dmy_q != '0) begin
          st_q  <= ST_DUMMY;
          cnt_q <= dmy_q - 7'd1;
        end else if (st_q != ST_DATA) begin
          st_q  <= ST_DATA;
          cnt_q <= dat_q - 7'd1;
        end else begin
          st_q <= ST_IDLE;
        end
      end
    end
  end

  assign st_o    = st_q;
  assign sclk_o  = sclk_q;
  assign shift_o = (st_q == ST_CMD) && sclk_q;
  assign smp_o   = (st_q == ST_DATA) && !sclk_q;
  assign done_o  = (st_q == ST_DATA) && sclk_q && (cnt_q == '0);

  // R11
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> (sclk_q != $past(sclk_q)));
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic        shift_i,
  input  logic [7:0]  op_i,
  input  logic [31:0] addr_i,
  input  logic [1:0]  abytes_i,
  output logic        bit_o
);
  logic [39:0] sr_q;
  logic [31:0] addr_al;

  // left-justify the low abytes+1 address bytes
  assign addr_al = addr_i << {2'd3 - abytes_i, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {op_i, addr_al};
    else if (shift_i) sr_q <= {sr_q[38:0], 1'b0};
  end

  assign bit_o = sr_q[39];
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        quad_i,
  input  logic        smp_i,
  input  logic [3:0]  lane_i,
  output logic [31:0] word_o
);
  logic [31:0] sr_q;
  logic        quad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      quad_q <= 1'b0;
    end else if (clr_i) begin
      sr_q   <= '0;
      quad_q <= quad_i;
    end else if (smp_i) begin
      sr_q <= quad_q ? {sr_q[27:0], lane_i} : {sr_q[30:0], lane_i[1]};
    end
  end

  // first byte received is least significant
  assign word_o = {sr_q[7:0], sr_q[15:8], sr_q[23:16], sr_q[31:24]};
endmodule

// File: rtl/sfr_xip_rd.sv
module sfr_xip_rd import sfr_pkg::*; #(
  parameter int NCS = 4,
  parameter int AW  = 32,
  localparam int CSW = $clog2(NCS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [31:0]    setup_i,
  input  logic           mem_sw_i,
  input  logic [CSW-1:0] cs_map_i,
  input  logic           bus_req_i,
  input  logic [AW-1:0]  bus_addr_i,
  output logic           bus_valid_o,
  output logic           bus_err_o,
  output logic [31:0]    bus_rdata_o,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_no,
  output logic           mosi_o,
  output logic           mosi_oe_o,
  input  logic [3:0]     lane_i
);
  setup_t      cfg;
  st_e         st;
  logic [NCS-1:0] cs_oh;
  logic        map_ok, idle, start, err_req, shift, smp, done, tx_bit, quad;
  logic [6:0]  cmd_bits, dmy_bits, dat_clks;
  logic [31:0] addr32, rx_word;

  logic [NCS-1:0] cs_q;
  logic        valid_q, err_q;
  logic [31:0] rdata_q;

  assign cfg      = setup_i;
  assign addr32   = 32'(bus_addr_i);
  assign quad     = (cfg.mode == MODE_QUAD);
  assign cmd_bits = 7'd16 + {2'b00, cfg.abytes, 3'b000};
  assign dmy_bits = {2'b00, cfg.dbytes, 3'b000} + {2'b00, cfg.dbits};
  assign dat_clks = quad ? 7'd8 : 7'd32;

  assign idle    = (st == ST_IDLE);
  assign start   = bus_req_i && idle && mem_sw_i && map_ok;
  assign err_req = bus_req_i && idle && !(mem_sw_i && map_ok);

  sfr_cs_dec #(.NCS(NCS)) u_dec (
    .map_i (cs_map_i),
    .oh_o  (cs_oh),
    .ok_o  (map_ok)
  );

  sfr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cmd_bits_i (cmd_bits),
    .dmy_bits_i (dmy_bits),
    .dat_clks_i (dat_clks),
    .st_o       (st),
    .sclk_o     (sclk_o),
    .shift_o    (shift),
    .smp_o      (smp),
    .done_o     (done)
  );

  sfr_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .shift_i  (shift),
    .op_i     (cfg.rd_op),
    .addr_i   (addr32),
    .abytes_i (cfg.abytes),
    .bit_o    (tx_bit)
  );

  sfr_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .quad_i (quad),
    .smp_i  (smp),
    .lane_i (lane_i),
    .word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= done || err_req;
      err_q   <= err_req;
      if (start)        cs_q <= ~cs_oh;
      else if (done)    cs_q <= '1;
      if (done)         rdata_q <= rx_word;
      else if (err_req) rdata_q <= '0;
    end
  end

  assign cs_no       = cs_q;
  assign bus_valid_o = valid_q;
  assign bus_err_o   = err_q;
  assign bus_rdata_o = rdata_q;
  assign mosi_oe_o   = (st == ST_CMD);
  assign mosi_o      = mosi_oe_o && tx_bit;

  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R8
  valid_cs_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (&cs_no));
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> ((&cs_no) && !sclk_o && bus_valid_o));
  // R11
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !sclk_o);
endmodule

// File: tb/sfr_xip_rd_tb.sv
`timescale 1ns/1ps
module sfr_xip_rd_tb_top;
  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int CSW = $clog2(NCS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]    setup;
  logic           mem_sw;
  logic [CSW-1:0] cs_map;
  logic           req;
  logic [AW-1:0]  addr;
  logic           valid, err;
  logic [31:0]    rdata;
  logic           sclk, mosi, mosi_oe;
  logic [NCS-1:0] cs_n;
  logic [3:0]     lane_drv;

  sfr_xip_rd #(.NCS(NCS), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .setup_i(setup), .mem_sw_i(mem_sw),
    .cs_map_i(cs_map), .bus_req_i(req), .bus_addr_i(addr),
    .bus_valid_o(valid), .bus_err_o(err), .bus_rdata_o(rdata),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .mosi_oe_o(mosi_oe),
    .lane_i(lane_drv)
  );

  int n_chk = 0, n_fail = 0;
  int rise, fall, oe_rise, cs_falls = 0, lg;
  bit quad_g;
  logic [63:0] tx_cap;
  logic [NCS-1:0] cs_seen;
  logic [AW-1:0] a_g;

  function automatic logic [7:0] fb(input int a);
    int t;
    t = (a * 29) ^ (a >>> 5) ^ 32'h5A;
    return t[7:0];
  endfunction

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  wire cs_act = ~&cs_n;
  always @(posedge cs_act) cs_falls++;

  always @(posedge sclk) if (cs_act) begin
    rise++;
    cs_seen = ~cs_n;
    if (mosi_oe) begin
      oe_rise++;
      tx_cap = {tx_cap[62:0], mosi};
    end
  end

  // flash model: output changes after each falling edge
  always @(negedge sclk) if (cs_act) begin
    fall++;
    if (fall >= lg) begin
      int j;
      logic [7:0] b;
      j = fall - lg;
      if (quad_g) begin
        if (j < 8) begin
          b = fb(int'(a_g) + j / 2);
          lane_drv = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
      end else if (j < 32) begin
        b = fb(int'(a_g) + j / 8);
        lane_drv = {2'b00, b[7 - j % 8], 1'b0};
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] s,
                    input logic [CSW-1:0] m, input bit sw, output int lat);
    lg      = 8 + 8 * (int'(s[9:8]) + 1) + 8 * int'(s[11:10]) + int'(s[28:24]);
    quad_g  = (s[13:12] == 2'd3);
    a_g     = a;
    rise = 0; fall = 0; oe_rise = 0; tx_cap = '0; lane_drv = '0; cs_seen = '0;
    @(negedge clk);
    setup = s; cs_map = m; mem_sw = sw; addr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!valid && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat, f0;
    logic [31:0] r_a, r_b;
    logic [63:0] t_a;
    setup = '0; mem_sw = 1'b0; cs_map = '0; req = 1'b0; addr = '0; lane_drv = '0;
    repeat (3) @(negedge clk);
    check(cs_n == '1, "R1 cs", cs_n, 4'hF);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(mosi_oe == 1'b0, "R1 oe", mosi_oe, 0);
    check(valid == 1'b0, "R1 valid", valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 error paths
    for (int k = 0; k < 3; k++) begin
      logic [CSW-1:0] m;
      bit sw;
      m  = (k == 0) ? 3'd1 : (k == 1) ? 3'd0 : 3'd5;
      sw = (k != 0);
      f0 = cs_falls;
      rd(24'h123456, 32'h0002_0203, m, sw, lat);
      check(lat == 1 && valid && err, "R9 err resp", {valid, err, 8'(lat)}, 10'h301);
      check(rdata == 0, "R9 rdata", rdata, 0);
      check(cs_falls == f0 && rise == 0, "R9 no pins", cs_falls - f0 + rise, 0);
      @(negedge clk);
    end

    for (int idx = 0; idx < 192; idx++) begin
      int ab, db, dbi, md, nab, nbits, dclk;
      logic [7:0] op, wop;
      logic [31:0] s, expw;
      logic [CSW-1:0] m;
      logic [AW-1:0] a;
      longint expt, mask;
      md  = idx % 4;
      dbi = (idx / 4) % 3;
      db  = (idx / 12) % 4;
      ab  = (idx / 48) % 4;
      dbi = (dbi == 0) ? 0 : (dbi == 1) ? 3 : 31;
      op  = (idx % 4 == 0) ? 8'h03 : (idx % 4 == 1) ? 8'h0B : (idx % 4 == 2) ? 8'h6B : 8'hC7;
      wop = 8'(idx * 7);
      m   = CSW'((idx / 3) % 4 + 1);
      a   = AW'(idx * 32'h01357B + 32'h0A0B0C);
      s   = {3'b000, 5'(dbi), wop, 2'b00, 2'(md), 2'(db), 2'(ab), op};
      rd(a, s, m, 1'b1, lat);
      nab   = ab + 1;
      nbits = 8 + 8 * nab;
      dclk  = (md == 3) ? 8 : 32;
      expw  = {fb(int'(a) + 3), fb(int'(a) + 2), fb(int'(a) + 1), fb(int'(a))};
      check(valid && !err, "R5 ok resp", {valid, err}, 2'b10);
      if (md == 3) check(rdata == expw, "R6 R7 quad data", rdata, expw);
      else         check(rdata == expw, "R5 R7 single data", rdata, expw);
      mask = (longint'(1) << nbits) - 1;
      expt = (longint'(op) << (8 * nab)) | (longint'(a) & ((longint'(1) << (8 * nab)) - 1));
      check((tx_cap & mask) == expt, "R2 R3 opcode+addr", tx_cap & mask, expt);
      check(oe_rise == nbits, "R4 lane0 drive span", oe_rise, nbits);
      check(rise == lg + dclk, (md == 3) ? "R6 sclk count" : "R5 sclk count", rise, lg + dclk);
      check(cs_seen == NCS'(1 << (int'(m) - 1)), "R8 cs select", cs_seen, 1 << (int'(m) - 1));
      check(cs_n == '1, "R8 cs released", cs_n, 4'hF);
      check(lat == 2 * (lg + dclk) + 1 && !sclk, "R11 latency", lat, 2 * (lg + dclk) + 1);
      @(negedge clk);
    end

    // R10 write opcode field has no effect
    rd(24'h00BEEF, 32'h0102_1503, 3'd2, 1'b1, lat);
    r_a = rdata; t_a = tx_cap; f0 = rise;
    @(negedge clk);
    rd(24'h00BEEF, 32'h01FD_1503, 3'd2, 1'b1, lat);
    r_b = rdata;
    check(r_a == r_b && t_a == tx_cap && f0 == rise, "R10 wr opcode ignored", r_b, r_a);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule